// File: doc/BRIEF.md
# Constant-off-time current limit regulator

This block regulates the peak load current of one H-bridge. An external comparator raises a flag when the load current crosses the active limit; the block answers by asking the gate drive to tri-state the bridge for a fixed off time. When that time has run out, the outputs switch back on. Every output switching event, including the return from an off time, opens a blanking window. During that window the limit comparator is ignored, so switching spikes cannot start a false off time.

A second comparator watches for short-circuit current. Its threshold lies well above the regulation limit. A trip of that comparator while the bridge conducts, whether inside blanking or after it, sends a one-cycle fault pulse to the bridge control logic. The control logic latches the bridge off. The block stays quiet until the bridge is brought down and restarted. A foldback flag from the temperature sensor selects the reduced current-limit threshold. All durations are set in microseconds and turned into clock cycles through a cycles-per-microsecond parameter.

Top module: `cot_current_limiter`

## Requirements
- R1: While reset is asserted and in the cycle after it with `bridge_live` low, `tristate_req`, `short_fault` and `lim_reduced` are all 0.
- R2: A limit trip sampled while the bridge is conducting and not blanked makes `tristate_req` 1 from the next cycle. It stays 1 for exactly OFF_US*CYC_PER_US consecutive cycles.
- R3: After an off time ends, a blanking window of exactly BLANK_US*CYC_PER_US cycles follows, and limit trips inside it are ignored. With the limit flag held at 1, `tristate_req` therefore stays 0 for BLANK_US*CYC_PER_US+1 cycles between two off times.
- R4: An `out_toggle` strobe sampled while conducting, whether blanked or not, restarts the blanking window at its full length.
- R5: A short trip sampled while conducting, whether blanked or not, gives `short_fault` = 1 for exactly one cycle, on the next cycle. After that the block issues neither pulses nor off times until `bridge_live` falls.
- R6: A short trip sampled during an off time produces no `short_fault` pulse.
- R7: When `bridge_live` is low, `tristate_req` is 0 from the next cycle and both timers are cleared. A rising `bridge_live` starts a fresh full blanking window.
- R8: `lim_reduced` equals the value of `hot_fold` sampled one clock earlier, independent of the regulation state (1 = reduced threshold).
- R9: An `out_toggle` strobe during an off time does not change the length of that off time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bridge_live | input | 1 | Bridge enabled, awake and not fault-latched |
| ilim_hit | input | 1 | Load current at or above the active limit |
| short_hit | input | 1 | Load current above the short-circuit threshold |
| out_toggle | input | 1 | One-cycle strobe on each commanded output transition |
| hot_fold | input | 1 | Junction temperature in the foldback region |
| tristate_req | output | 1 | Request to tri-state the bridge for the off time |
| short_fault | output | 1 | One-cycle short-circuit fault request |
| lim_reduced | output | 1 | Selects the reduced current-limit threshold |

## Verification
The assertions assume that all comparator flags and strobes are synchronous to `clk` and are sampled only at its rising edge. They also assume that `bridge_live` falls after a fault pulse, as the bridge control latch would make it do. The bench changes every input one nanosecond after a rising edge. It never holds `bridge_live` high across a fault for longer than the directed check of the fault hold needs, and it releases it afterwards. This covers the stay-quiet behaviour without relying on an external latch model.

// File: rtl/cot_pkg.sv
// Shared types for the constant-off-time regulator.
// Assumes: one regulator per bridge, all inputs synchronous to the clock.
package cot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // bridge not live, timers held
        ST_BLANK = 3'd1,  // conducting, limit comparator masked
        ST_ON    = 3'd2,  // conducting, limit comparator honoured
        ST_OFF   = 3'd3,  // fixed off time, tri-state requested
        ST_FAULT = 3'd4   // short seen, waiting for bridge to drop
    } reg_state_t;

    // Converts a duration in microseconds to clock cycles.
    function automatic int us_to_cycles(input int us, input int cyc_per_us);
        return us * cyc_per_us;
    endfunction

endpackage

// File: rtl/cot_span_timer.sv
// One-shot interval timer: after start it reports busy for exactly LEN cycles.
// Assumes: LEN >= 1; clr overrides start.
module cot_span_timer #(
    parameter int LEN = 8,
    localparam int W = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic last
);

    logic [W-1:0] cnt_q;

    // Load, count down and expire the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= W'(LEN - 1);
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Final busy cycle marker.
    always_comb last = busy && (cnt_q == '0);

endmodule

// File: rtl/cot_limit_sel.sv
// Registers the foldback flag into the threshold-select output.
// Assumes: hot flag is already synchronous to clk.
module cot_limit_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_fold,
    output logic lim_reduced
);

    // One-cycle registered threshold choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_reduced <= 1'b0;
        end else begin
            lim_reduced <= hot_fold;
        end
    end

endmodule

// File: rtl/cot_reg_fsm.sv
// Regulation sequencer: blanking, on-time, fixed off time and fault hand-off.
// Assumes: timers report busy for exactly their programmed length after start.
module cot_reg_fsm
    import cot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic ilim_hit,
    input  logic short_hit,
    input  logic toggle,
    input  logic off_busy,
    input  logic off_last,
    input  logic blank_busy,
    input  logic blank_last,
    output logic off_start,
    output logic blank_start,
    output logic tmr_clr,
    output logic tristate_req,
    output logic fault_pulse
);

    reg_state_t st_q, st_d;

    // Next-state and timer start decisions; short beats toggle beats limit.
    always_comb begin
        st_d        = st_q;
        off_start   = 1'b0;
        blank_start = 1'b0;
        if (!live) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d        = ST_BLANK;
                    blank_start = 1'b1;
                end
                ST_BLANK: begin
                    if (short_hit) begin
                        st_d = ST_FAULT;
                    end else if (toggle) begin
                        blank_start = 1'b1;
                    end else if (blank_last) begin
                        st_d = ST_ON;
                    end
                end
                ST_ON: begin
                    if (short_hit) begin
                        st_d = ST_FAULT;
                    end else if (toggle) begin
                        st_d        = ST_BLANK;
                        blank_start = 1'b1;
                    end else if (ilim_hit) begin
                        st_d      = ST_OFF;
                        off_start = 1'b1;
                    end
                end
                ST_OFF: begin
                    if (off_last) begin
                        st_d        = ST_BLANK;
                        blank_start = 1'b1;
                    end
                end
                ST_FAULT: st_d = ST_FAULT;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // Timers are held clear when not live or once a fault is taken.
    always_comb tmr_clr = !live || (st_d == ST_FAULT);

    // State register and one-cycle fault request on entry to fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            fault_pulse <= 1'b0;
        end else begin
            st_q        <= st_d;
            fault_pulse <= (st_d == ST_FAULT) && (st_q != ST_FAULT);
        end
    end

    // Tri-state is requested only during the off time.
    always_comb tristate_req = (st_q == ST_OFF);

    AST_OFF_TRACKS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) == off_busy); // R2

    AST_NO_TRIP_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLANK && live) |=> (st_q != ST_OFF)); // R3

    AST_TOGGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (live && toggle && !short_hit && (st_q == ST_ON || st_q == ST_BLANK))
        |=> (blank_busy && st_q == ST_BLANK)); // R4

    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse); // R5

    AST_OFF_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && short_hit) |=> !fault_pulse); // R6

    AST_DEAD_TIMERS: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (!off_busy && !blank_busy && !tristate_req)); // R7

    AST_OFF_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && live && !off_last) |=> (st_q == ST_OFF)); // R9

endmodule

// File: rtl/cot_current_limiter.sv
// Constant-off-time peak current regulator for one H-bridge.
// Assumes: comparator flags and toggle strobe are synchronous to clk;
// the bridge control block drops bridge_live after a short_fault pulse.
module cot_current_limiter #(
    parameter int CYC_PER_US = 125,
    parameter int OFF_US     = 20,
    parameter int BLANK_US   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bridge_live,
    input  logic ilim_hit,
    input  logic short_hit,
    input  logic out_toggle,
    input  logic hot_fold,
    output logic tristate_req,
    output logic short_fault,
    output logic lim_reduced
);
    import cot_pkg::*;

    localparam int OFF_CYC   = us_to_cycles(OFF_US, CYC_PER_US);
    localparam int BLANK_CYC = us_to_cycles(BLANK_US, CYC_PER_US);
    localparam int N_TMR     = 2;   // index 0: off time, 1: blanking

    logic [N_TMR-1:0] t_start, t_busy, t_last;
    logic             tmr_clr;

    // Timer bank: one interval timer per programmed duration.
    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        cot_span_timer #(
            .LEN ((gi == 0) ? OFF_CYC : BLANK_CYC)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (tmr_clr),
            .start (t_start[gi]),
            .busy  (t_busy[gi]),
            .last  (t_last[gi])
        );
    end

    cot_reg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .live         (bridge_live),
        .ilim_hit     (ilim_hit),
        .short_hit    (short_hit),
        .toggle       (out_toggle),
        .off_busy     (t_busy[0]),
        .off_last     (t_last[0]),
        .blank_busy   (t_busy[1]),
        .blank_last   (t_last[1]),
        .off_start    (t_start[0]),
        .blank_start  (t_start[1]),
        .tmr_clr      (tmr_clr),
        .tristate_req (tristate_req),
        .fault_pulse  (short_fault)
    );

    cot_limit_sel u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_fold    (hot_fold),
        .lim_reduced (lim_reduced)
    );

    AST_OFF_THEN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tristate_req) && bridge_live && $past(bridge_live)) |-> t_busy[1]); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tristate_req && !short_fault && !lim_reduced)); // R1

endmodule

// File: tb/cot_current_limiter_bench.sv
`timescale 1ns/1ps
module cot_current_limiter_bench;

    localparam int CPU = 2;
    localparam int OFF_US = 3;
    localparam int BLK_US = 2;
    localparam int OFF_N = OFF_US * CPU;   // 6 cycles
    localparam int BLK_N = BLK_US * CPU;   // 4 cycles
    localparam int NV = 17;

    // {live, ilim, short, toggle, hot, exp_tri, exp_flt, exp_red}
    localparam logic [7:0] VEC [NV] = '{
        8'b00000_000, // 0  R1 idle after reset
        8'b10001_001, // 1  R8 go live, blank starts, reduced follows hot
        8'b11001_001, // 2  R3 limit ignored in blanking
        8'b11001_001, // 3  R3
        8'b11001_001, // 4  R3
        8'b11001_001, // 5  R3 blanking expires at this edge
        8'b11000_100, // 6  R2 off time starts
        8'b10100_100, // 7  R6 short during off ignored
        8'b10010_100, // 8  R9 toggle during off ignored
        8'b10000_100, // 9  R2
        8'b10000_100, // 10 R2
        8'b10000_100, // 11 R2 last off cycle
        8'b10000_000, // 12 R2 off ends, blanking again
        8'b10100_010, // 13 R5 short in blanking
        8'b10100_000, // 14 R5 single pulse
        8'b11000_000, // 15 R5 no off time after fault
        8'b00000_000  // 16 R7 drop live
    };
    localparam int VREQ [NV] = '{1,8,3,3,3,3,2,6,9,2,2,2,2,5,5,5,7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic live = 1'b0, ilim = 1'b0, shrt = 1'b0, tgl = 1'b0, hot = 1'b0;
    logic tri_o, flt_o, red_o;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    cot_current_limiter #(
        .CYC_PER_US (CPU),
        .OFF_US     (OFF_US),
        .BLANK_US   (BLK_US)
    ) u_cot_current_limiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .bridge_live  (live),
        .ilim_hit     (ilim),
        .short_hit    (shrt),
        .out_toggle   (tgl),
        .hot_fold     (hot),
        .tristate_req (tri_o),
        .short_fault  (flt_o),
        .lim_reduced  (red_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Counts consecutive samples (current one included) where tri_o == v.
    task automatic run_len(input logic v, output int n);
        n = 1;
        step();
        while (tri_o == v && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic idle_then_live(input logic lim_v);
        live = 1'b0; ilim = 1'b0; shrt = 1'b0; tgl = 1'b0;
        step();
        live = 1'b1; ilim = lim_v;
        step();
    endtask

    initial begin
        int n;
        hot = 1'b1;
        repeat (3) step();
        // R1: outputs quiet under reset even with hot flag high
        check("R1 tri in reset", tri_o, 0);
        check("R1 fault in reset", flt_o, 0);
        check("R1 sel in reset", red_o, 0);
        hot = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {live, ilim, shrt, tgl, hot} = VEC[i][7:3];
            step();
            check($sformatf("R%0d row %0d tri", VREQ[i], i), tri_o, VEC[i][2]);
            check($sformatf("R%0d row %0d fault", VREQ[i], i), flt_o, VEC[i][1]);
            check($sformatf("R%0d row %0d sel", VREQ[i], i), red_o, VEC[i][0]);
        end

        // R2 / R3 / R7: periodic regulation with limit held high
        idle_then_live(1'b1);
        run_len(1'b0, n); check("R7 blank after going live", n, BLK_N + 1);
        run_len(1'b1, n); check("R2 off length", n, OFF_N);
        run_len(1'b0, n); check("R3 gap between offs", n, BLK_N + 1);
        run_len(1'b1, n); check("R2 off length again", n, OFF_N);

        // R4: toggle inside blanking restarts it
        idle_then_live(1'b0);
        step(); step();
        tgl = 1'b1; ilim = 1'b1;
        step();
        tgl = 1'b0;
        run_len(1'b0, n); check("R4 restart in blanking", n, BLK_N + 1);

        // R4: toggle during on-time reopens blanking
        idle_then_live(1'b0);
        repeat (BLK_N) step();
        tgl = 1'b1; ilim = 1'b1;
        step();
        tgl = 1'b0;
        run_len(1'b0, n); check("R4 restart from on-time", n, BLK_N + 1);

        // R5: short in on-time, one pulse then quiet
        idle_then_live(1'b0);
        repeat (BLK_N) step();
        shrt = 1'b1;
        step(); check("R5 pulse in on-time", flt_o, 1);
        step(); check("R5 pulse ends", flt_o, 0);
        shrt = 1'b0; ilim = 1'b1;
        repeat (BLK_N + 3) step();
        check("R5 no off after fault", tri_o, 0);
        check("R5 no second pulse", flt_o, 0);

        // R7: dropping live during off clears timers
        idle_then_live(1'b1);
        run_len(1'b0, n);
        step(); step();
        live = 1'b0;
        step(); check("R7 tri drops when not live", tri_o, 0);
        live = 1'b1;
        step();
        run_len(1'b0, n); check("R7 fresh blank after restart", n, BLK_N + 1);

        // R8: threshold select follows foldback during off
        hot = 1'b1; step(); check("R8 reduced on", red_o, 1);
        hot = 1'b0; step(); check("R8 reduced off", red_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule